// File: doc/BRIEF.md
# Burst Address Counter Memory Port

This block is one synchronous port of a word-wide single-clock memory. It carries an internal burst address counter, so a master can issue one start address and then stream words without driving the address bus again. On every rising clock edge the port picks the access address from one of four sources: zero (counter clear), the external address bus (load), the counter plus one (step), or the counter unchanged (hold). The read or write of that same edge uses the picked address, and the counter takes that address as its new value.

Each word is split into byte lanes of `LANE_W` bits, and each lane has its own active-low write enable. Reads go through one pipeline register. The data and a valid flag appear after the edge that sampled the read request. `ADDR_W` sets the depth. A full-size port uses `ADDR_W = 15` (32768 words of 36 bits). The default is smaller so that elaboration stays light.

Top module: `bac_port`

## Requirements
- R1: With `clr_n` high and `load_n` low, the access address of an edge is `addr_in` sampled at that edge, and the counter takes that value.
- R2: With `clr_n` and `load_n` high and `step_n` low, the access address is the previous counter value plus one. The access of that edge goes to the new address.
- R3: With `clr_n`, `load_n` and `step_n` all high, the access address and the counter stay at the previous counter value.
- R4: With `clr_n` low, the access address is 0 whatever `load_n` and `step_n` are. A read or write on that same edge goes to address 0.
- R5: Stepping from address 2^ADDR_W-1 wraps the counter and the access address to 0.
- R6: A write occurs when `cs_n` and `wr_n` are both low. Bit i of `lane_en_n`, when low, writes bits [LANE_W*i+LANE_W-1 : LANE_W*i] (lane 0 is the least significant). Lanes whose enable is high keep their old contents.
- R7: A read occurs when `cs_n` is low and `wr_n` is high. After the sampling edge, `rdata` holds the word at the access address and `rvalid` is high for that cycle.
- R8: After an edge with `cs_n` high or `wr_n` low, `rvalid` is low and `rdata` keeps its previous value.
- R9: The counter loads, steps, holds and clears the same way when `cs_n` is high.
- R10: Synchronous active-high `rst` clears the counter to 0 and `rvalid` to 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Port select, active low |
| wr_n | input | 1 | Low selects write, high selects read |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| load_n | input | 1 | Load the counter from `addr_in`, active low |
| step_n | input | 1 | Advance the counter by one, active low |
| clr_n | input | 1 | Clear the counter to 0, active low |
| addr_in | input | ADDR_W | External address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | High while `rdata` carries the result of the previous edge's read |

## Verification
The bench first writes words with a load, a step, a hold and a clear, then reads them back in the same order. A port that used the old counter value on a step edge, or let a clear take effect only on the following edge, would return the word one address away. A clear issued together with a load checks the priority: a design that let the load win would read address 5 instead of 0. Stepping from the top address checks the wrap; a counter with one extra bit would leave the array. The remaining cases are a lane-masked write, a write with every lane disabled, a counter loaded while the port is deselected, and a reset in the middle of a run. A design that ignored the per-lane enables would corrupt the neighbouring lanes. A counter gated by `cs_n`, or a reset that left the counter alone, would read the wrong word.

// File: rtl/bac_pkg.sv
package bac_pkg;

  // Number of byte lanes in one word and their width
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 9;

  // Source of the access address, in priority order
  typedef enum logic [1:0] {
    SRC_CLEAR = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_STEP  = 2'd2,
    SRC_HOLD  = 2'd3
  } addr_src_e;

  function automatic addr_src_e pick_src(input logic clr_n,
                                         input logic load_n,
                                         input logic step_n);
    if (!clr_n)       return SRC_CLEAR;
    else if (!load_n) return SRC_LOAD;
    else if (!step_n) return SRC_STEP;
    else              return SRC_HOLD;
  endfunction

endpackage

// File: rtl/bac_addr_ctrl.sv
module bac_addr_ctrl
  import bac_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              step_n,
  input  logic              clr_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] cnt_q
);

  addr_src_e src;

  always_comb begin
    src = pick_src(clr_n, load_n, step_n);
    unique case (src)
      SRC_CLEAR: acc_addr = '0;
      SRC_LOAD:  acc_addr = addr_in;
      SRC_STEP:  acc_addr = cnt_q + ADDR_W'(1);
      default:   acc_addr = cnt_q;
    endcase
  end

  // The counter follows the address used this edge; it runs whether or
  // not the port is selected, and wraps naturally at ADDR_W bits.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= acc_addr;
  end

endmodule

// File: rtl/bac_access_dec.sv
module bac_access_dec #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_en_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_en,
  output logic             rvalid
);

  logic sel;

  always_comb begin
    sel   = !cs_n;
    rd_en = sel && wr_n;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_we
    always_comb lane_we[g] = sel && !wr_n && !lane_en_n[g];
  end

  // Valid flag lines up with the registered read data
  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= rd_en;
  end

endmodule

// File: rtl/bac_lane_ram.sv
module bac_lane_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Single-port, read-first; the read register is the output pipeline
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd <= mem[addr];
  end

endmodule

// File: rtl/bac_port.sv
module bac_port
  import bac_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    load_n,
  input  logic                    step_n,
  input  logic                    clr_n,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] cnt_q;
  logic [LANES-1:0]  lane_we;
  logic              rd_en;

  bac_addr_ctrl #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .step_n   (step_n),
    .clr_n    (clr_n),
    .addr_in  (addr_in),
    .acc_addr (acc_addr),
    .cnt_q    (cnt_q)
  );

  bac_access_dec #(.LANES(LANES)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .lane_en_n (lane_en_n),
    .lane_we   (lane_we),
    .rd_en     (rd_en),
    .rvalid    (rvalid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bac_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk  (clk),
      .addr (acc_addr),
      .we   (lane_we[g]),
      .re   (rd_en),
      .wd   (wdata[g*LANE_W +: LANE_W]),
      .rd   (rdata[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/bac_port_chk.sv
module bac_port_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wr_n,
  input logic              load_n,
  input logic              step_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] cnt_q,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid
);

  a_r1_load_takes_bus: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> (cnt_q == $past(addr_in)));

  a_r2_step_adds_one: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !step_n) |=> (cnt_q == ADDR_W'($past(cnt_q) + 1'b1)));

  a_r3_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && step_n) |=> $stable(cnt_q));

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (cnt_q == '0));

  a_r7_read_valid: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && wr_n) |=> rvalid);

  a_r8_no_read_no_valid: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !wr_n) |=> (!rvalid && $stable(rdata)));

endmodule

bind bac_port bac_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .wr_n    (wr_n),
  .load_n  (load_n),
  .step_n  (step_n),
  .clr_n   (clr_n),
  .addr_in (addr_in),
  .cnt_q   (cnt_q),
  .rdata   (rdata),
  .rvalid  (rvalid)
);

// File: tb/tb_bac_port.sv
`timescale 1ns/1ps
module tb_bac_port;

  localparam int unsigned AW = 10;
  localparam int unsigned NL = 4;
  localparam int unsigned DW = 36;

  logic          clk = 1'b0;
  logic          rst;
  logic          cs_n, wr_n, load_n, step_n, clr_n;
  logic [NL-1:0] lane_en_n;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  bac_port #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .lane_en_n(lane_en_n),
    .load_n(load_n), .step_n(step_n), .clr_n(clr_n), .addr_in(addr_in),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct packed {
    logic [23:0]   tag;
    logic          cs;
    logic          wr;
    logic [NL-1:0] be;
    logic          ld;
    logic          st;
    logic          clr;
    logic [AW-1:0] adr;
    logic [DW-1:0] wd;
    logic          ev;
    logic [DW-1:0] ed;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{"R1 ", 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 10'd5,    36'h111111111, 1'b0, 36'h0},
    '{"R2 ", 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 10'd0,    36'h222222222, 1'b0, 36'h0},
    '{"R3 ", 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 10'd0,    36'h333333333, 1'b0, 36'h0},
    '{"R4 ", 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 10'd0,    36'h444444444, 1'b0, 36'h0},
    '{"R2 ", 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 10'd0,    36'h555555555, 1'b0, 36'h0},
    '{"R1 ", 1'b0, 1'b1, 4'hf, 1'b0, 1'b1, 1'b1, 10'd5,    36'h0,         1'b1, 36'h111111111},
    '{"R3 ", 1'b0, 1'b1, 4'hf, 1'b1, 1'b0, 1'b1, 10'd0,    36'h0,         1'b1, 36'h333333333},
    '{"R4 ", 1'b0, 1'b1, 4'hf, 1'b0, 1'b1, 1'b0, 10'd5,    36'h0,         1'b1, 36'h444444444},
    '{"R7 ", 1'b0, 1'b1, 4'hf, 1'b1, 1'b0, 1'b1, 10'd0,    36'h0,         1'b1, 36'h555555555},
    '{"R6 ", 1'b0, 1'b0, 4'ha, 1'b0, 1'b1, 1'b1, 10'd6,    36'hfffffffff, 1'b0, 36'h0},
    '{"R6 ", 1'b0, 1'b1, 4'hf, 1'b1, 1'b1, 1'b1, 10'd0,    36'h0,         1'b1, 36'h337ff33ff},
    '{"R8 ", 1'b1, 1'b1, 4'hf, 1'b0, 1'b1, 1'b1, 10'd4,    36'h0,         1'b0, 36'h0},
    '{"R9 ", 1'b0, 1'b1, 4'hf, 1'b1, 1'b0, 1'b1, 10'd0,    36'h0,         1'b1, 36'h111111111},
    '{"R6 ", 1'b0, 1'b0, 4'hf, 1'b1, 1'b1, 1'b1, 10'd0,    36'h999999999, 1'b0, 36'h0},
    '{"R6 ", 1'b0, 1'b1, 4'hf, 1'b1, 1'b1, 1'b1, 10'd0,    36'h0,         1'b1, 36'h111111111},
    '{"R5 ", 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 10'd1023, 36'h0f0f0f0f0, 1'b0, 36'h0},
    '{"R5 ", 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 10'd0,    36'h123456789, 1'b0, 36'h0},
    '{"R5 ", 1'b0, 1'b1, 4'hf, 1'b0, 1'b1, 1'b1, 10'd0,    36'h0,         1'b1, 36'h123456789},
    '{"R5 ", 1'b0, 1'b1, 4'hf, 1'b0, 1'b1, 1'b1, 10'd1023, 36'h0,         1'b1, 36'h0f0f0f0f0}
  };

  task automatic drive(input vec_t v);
    cs_n = v.cs; wr_n = v.wr; lane_en_n = v.be;
    load_n = v.ld; step_n = v.st; clr_n = v.clr;
    addr_in = v.adr; wdata = v.wd;
  endtask

  task automatic check(input logic [23:0] tag, input logic ev,
                       input logic dchk, input logic [DW-1:0] ed);
    vectors++;
    if (rvalid !== ev || (dchk && rdata !== ed)) begin
      miscompares++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, ev, ed);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    vec_t idle;
    idle = '{"R10", 1'b1, 1'b1, 4'hf, 1'b1, 1'b1, 1'b1, 10'd0, 36'h0, 1'b0, 36'h0};
    rst = 1'b1;
    drive(idle);
    repeat (3) @(negedge clk);
    check("R10", 1'b0, 1'b0, 36'h0);     // reset state
    rst = 1'b0;

    // Table walk: drive at a falling edge, sample at the next falling edge
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check(VECS[i].tag, VECS[i].ev, VECS[i].ev, VECS[i].ed);
    end

    // R8: a deselected cycle keeps the last read word and drops valid
    drive(idle);
    @(negedge clk);
    check("R8 ", 1'b0, 1'b1, 36'h0f0f0f0f0);

    // R10: reset in mid-run clears valid and the counter (it held 1023)
    rst = 1'b1;
    @(negedge clk);
    check("R10", 1'b0, 1'b0, 36'h0);
    rst = 1'b0;
    drive('{"R10", 1'b0, 1'b1, 4'hf, 1'b1, 1'b1, 1'b1, 10'd77, 36'h0, 1'b0, 36'h0});
    @(negedge clk);
    check("R10", 1'b1, 1'b1, 36'h123456789);   // hold reads address 0

    drive(idle);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule